// File: doc/BRIEF.md
# USB Port Ownership Router

This block stands between ten physical USB 2.0 ports, the high-speed host side and five full/low-speed companion controllers. For every port it keeps one ownership bit that says whether the high-speed side or the port's companion owns the port. The owner's transmit lines and transmit enable reach the port. Only the owner sees the port's receive lines and connection state. The other side sees a disconnected port with idle receive lines.

Each companion serves one fixed pair of adjacent ports: port p belongs to companion p/2. The high-speed side is split into two groups. Ports 0 to 5 report to the first group and ports 6 to 9 to the second. Ownership moves to the companion when the global configured flag is clear or when the attached device cannot signal at high speed. It returns to the high-speed side when the flag rises and when a device detaches. Between those events, the high-speed controller can hand a port over or take it back with a per-port write strobe. Each side gets a one-cycle connect-change pulse whenever its view of a port changes. These pulses are also ORed into per-controller summaries.

Top module: `usb_port_owner_router`

## Requirements
- R1: Port p maps to companion summary bit `cmp_chg[p/2]`. Ports 0–5 map to `hs_chg[0]` and ports 6–9 map to `hs_chg[1]`.
- R2: A clock edge that samples `cfg_flag` low leaves every bit of `port_owned_cmp` at 1 (1 = companion owns, 0 = high-speed side owns).
- R3: The edge that first samples `cfg_flag` high after it was low gives every port to the high-speed side, unless R4 applies to that port.
- R4: While `cfg_flag` is high, an edge that samples a port with `phy_conn`=1 and `dev_hs_cap`=0 gives that port to the companion. No owner write overrides this.
- R5: An edge with `own_wr_en[p]`=1 sets the owner of port p to `own_wr_val[p]` (1 = companion), unless R2, R3, R4 or R6 decides that port.
- R6: With `cfg_flag` high, an edge at which `phy_conn[p]` falls from 1 to 0 returns port p to the high-speed side.
- R7: `port_tx` and `port_tx_en` for each port come from the companion's transmit inputs when `port_owned_cmp` is 1 and from the high-speed inputs otherwise. The switch happens in the same cycle as the ownership change.
- R8: The owner sees `phy_conn` and `phy_rx` of the port. The non-owner sees a connection of 0 and receive bits of 0.
- R9: Each `*_csc` bit is high for exactly the one cycle that follows a change in that side's view of the port's connection. The `*_chg` outputs are the OR of these bits over each controller's ports.
- R10: After reset every port is owned by its companion and no connect-change pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_flag | input | 1 | Global configured flag from high-speed software |
| phy_conn | input | 10 | Device attached, per port |
| dev_hs_cap | input | 10 | Attached device can signal at high speed, per port |
| phy_rx | input | 20 | Receive lines, 2 per port |
| own_wr_en | input | 10 | Owner write strobe, per port |
| own_wr_val | input | 10 | Owner write value, 1 = companion |
| hs_tx | input | 20 | High-speed side transmit lines |
| hs_tx_en | input | 10 | High-speed side transmit enables |
| cmp_tx | input | 20 | Companion transmit lines, indexed by port |
| cmp_tx_en | input | 10 | Companion transmit enables, indexed by port |
| port_tx | output | 20 | Transmit lines to the ports |
| port_tx_en | output | 10 | Transmit enables to the ports |
| port_owned_cmp | output | 10 | Ownership state, 1 = companion |
| hs_conn_view | output | 10 | Connection as seen by the high-speed side |
| hs_rx | output | 20 | Receive lines as seen by the high-speed side |
| hs_csc | output | 10 | High-speed side connect-change pulses |
| hs_chg | output | 2 | Per-group summary of `hs_csc` |
| cmp_conn_view | output | 10 | Connection as seen by the companions |
| cmp_rx | output | 20 | Receive lines as seen by the companions |
| cmp_csc | output | 10 | Companion connect-change pulses |
| cmp_chg | output | 5 | Per-companion summary of `cmp_csc` |

## Verification
A wrong ownership bit shows up as soon as the next sample after the edge that set it. The wrong controller's transmit pattern appears on `port_tx`, a connected port shows up on the wrong side's view, and the connect-change pulse fires on the wrong controller or is missing. The bench therefore checks the views, the transmit mux and the pulses one cycle after each event: a flag edge, a full-speed attach, an owner write or a detach. It also checks that the pulses have died down one cycle later. Running every port through the mapping one at a time exposes any mis-wired pair or group.

// File: rtl/usb_port_owner_router.sv
module usb_port_owner_router #(
  parameter int NUM_PORTS = 10,
  parameter int PAIR      = 2,
  parameter int HS0_PORTS = 6,
  parameter int TXW       = 2,
  parameter int RXW       = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_flag,
  input  logic [NUM_PORTS-1:0]     phy_conn,
  input  logic [NUM_PORTS-1:0]     dev_hs_cap,
  input  logic [NUM_PORTS*RXW-1:0] phy_rx,
  input  logic [NUM_PORTS-1:0]     own_wr_en,
  input  logic [NUM_PORTS-1:0]     own_wr_val,
  input  logic [NUM_PORTS*TXW-1:0] hs_tx,
  input  logic [NUM_PORTS-1:0]     hs_tx_en,
  input  logic [NUM_PORTS*TXW-1:0] cmp_tx,
  input  logic [NUM_PORTS-1:0]     cmp_tx_en,
  output logic [NUM_PORTS*TXW-1:0] port_tx,
  output logic [NUM_PORTS-1:0]     port_tx_en,
  output logic [NUM_PORTS-1:0]     port_owned_cmp,
  output logic [NUM_PORTS-1:0]     hs_conn_view,
  output logic [NUM_PORTS*RXW-1:0] hs_rx,
  output logic [NUM_PORTS-1:0]     hs_csc,
  output logic [1:0]               hs_chg,
  output logic [NUM_PORTS-1:0]     cmp_conn_view,
  output logic [NUM_PORTS*RXW-1:0] cmp_rx,
  output logic [NUM_PORTS-1:0]     cmp_csc,
  output logic [NUM_PORTS/PAIR-1:0] cmp_chg
);
  localparam int NUM_COMP = NUM_PORTS / PAIR;

  logic [NUM_PORTS-1:0] own_q, own_d, conn_q, hs_view_q, cmp_view_q;
  logic                 cfg_q, cfg_rise;

  assign cfg_rise = cfg_flag & ~cfg_q;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (!cfg_flag)                        own_d[p] = 1'b1;
      else if (phy_conn[p] && !dev_hs_cap[p]) own_d[p] = 1'b1;
      else if (cfg_rise)                    own_d[p] = 1'b0;
      else if (conn_q[p] && !phy_conn[p])   own_d[p] = 1'b0;
      else if (own_wr_en[p])                own_d[p] = own_wr_val[p];
      else                                  own_d[p] = own_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q      <= '1;
      conn_q     <= '0;
      cfg_q      <= 1'b0;
      hs_view_q  <= '0;
      cmp_view_q <= '0;
    end else begin
      own_q      <= own_d;
      conn_q     <= phy_conn;
      cfg_q      <= cfg_flag;
      hs_view_q  <= hs_conn_view;
      cmp_view_q <= cmp_conn_view;
    end
  end

  assign port_owned_cmp = own_q;
  assign hs_conn_view   = phy_conn & ~own_q;
  assign cmp_conn_view  = phy_conn & own_q;
  assign hs_csc         = hs_conn_view ^ hs_view_q;
  assign cmp_csc        = cmp_conn_view ^ cmp_view_q;
  assign port_tx_en     = (cmp_tx_en & own_q) | (hs_tx_en & ~own_q);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_tx[p*TXW +: TXW] = own_q[p] ? cmp_tx[p*TXW +: TXW] : hs_tx[p*TXW +: TXW];
    assign hs_rx[p*RXW +: RXW]   = own_q[p] ? '0 : phy_rx[p*RXW +: RXW];
    assign cmp_rx[p*RXW +: RXW]  = own_q[p] ? phy_rx[p*RXW +: RXW] : '0;

    AST_DETACH_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flag && $fell(phy_conn[p])) |=> (port_owned_cmp[p] == 1'b0)); // R6
    AST_TX_FROM_HS: assert property (@(posedge clk) disable iff (!rst_n)
      hs_conn_view[p] |-> (port_tx_en[p] == hs_tx_en[p])); // R7
  end

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    assign cmp_chg[c] = |cmp_csc[c*PAIR +: PAIR];
  end

  assign hs_chg[0] = |hs_csc[HS0_PORTS-1:0];
  assign hs_chg[1] = |hs_csc[NUM_PORTS-1:HS0_PORTS];

  AST_UNCFG_ALL_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag |=> (hs_conn_view == '0)); // R2
  AST_FS_TO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flag |=> (($past(phy_conn & ~dev_hs_cap) & phy_conn & ~cmp_conn_view) == '0)); // R4
  AST_RISE_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_flag) && ((phy_conn & ~dev_hs_cap) == '0)) |=> (cmp_conn_view == '0)); // R3
endmodule

// File: tb/usb_port_owner_router_tb.sv
module usb_port_owner_router_tb_top;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_flag;
  logic [N-1:0] phy_conn, dev_hs_cap, own_wr_en, own_wr_val, hs_tx_en, cmp_tx_en;
  logic [2*N-1:0] phy_rx, hs_tx, cmp_tx;
  logic [2*N-1:0] port_tx, hs_rx, cmp_rx;
  logic [N-1:0] port_tx_en, port_owned_cmp, hs_conn_view, hs_csc, cmp_conn_view, cmp_csc;
  logic [1:0] hs_chg;
  logic [4:0] cmp_chg;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_port_owner_router dut_i (
    .clk, .rst_n, .cfg_flag, .phy_conn, .dev_hs_cap, .phy_rx, .own_wr_en, .own_wr_val,
    .hs_tx, .hs_tx_en, .cmp_tx, .cmp_tx_en, .port_tx, .port_tx_en, .port_owned_cmp,
    .hs_conn_view, .hs_rx, .hs_csc, .hs_chg, .cmp_conn_view, .cmp_rx, .cmp_csc, .cmp_chg);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [2*N-1:0] exp_tx(input logic [N-1:0] own);
    logic [2*N-1:0] r;
    for (int p = 0; p < N; p++) r[2*p +: 2] = own[p] ? cmp_tx[2*p +: 2] : hs_tx[2*p +: 2];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_en(input logic [N-1:0] own);
    return (cmp_tx_en & own) | (hs_tx_en & ~own);
  endfunction

  task automatic t_reset();
    chk("R10 owner after reset", port_owned_cmp, 10'h3FF);
    chk("R10 hs csc idle", hs_csc, 0);
    chk("R10 cmp csc idle", cmp_csc, 0);
    chk("R7 tx from companions", port_tx, exp_tx(10'h3FF));
    chk("R7 tx_en from companions", port_tx_en, exp_en(10'h3FF));
  endtask

  task automatic t_mapping();
    for (int p = 0; p < N; p++) begin
      phy_conn = 10'(1) << p;
      #1;
      chk($sformatf("R8 cmp view port %0d", p), cmp_conn_view, 10'(1) << p);
      chk($sformatf("R8 hs view port %0d", p), hs_conn_view, 0);
      chk($sformatf("R1 R9 cmp_chg port %0d", p), cmp_chg, 5'(1) << (p / 2));
      chk($sformatf("R1 hs_chg quiet port %0d", p), hs_chg, 0);
      step();
      chk($sformatf("R9 cmp csc one cycle port %0d", p), cmp_csc, 0);
      phy_conn = '0;
      step();
    end
  endtask

  task automatic t_cfg_rise();
    cfg_flag = 1'b1;
    step();
    chk("R3 all hs after rise", port_owned_cmp, 0);
    chk("R7 tx from hs", port_tx, exp_tx(0));
    phy_conn = 10'h080;
    phy_rx = 20'h0C000 | 20'h00003;
    #1;
    chk("R8 hs view port 7", hs_conn_view, 10'h080);
    chk("R1 hs_chg group 1", hs_chg, 2'b10);
    chk("R8 cmp view empty", cmp_conn_view, 0);
    chk("R8 hs rx", hs_rx, phy_rx);
    chk("R8 cmp rx blank", cmp_rx, 0);
    step();
    phy_conn = 10'h088;
    #1;
    chk("R1 hs_chg group 0", hs_chg, 2'b01);
    step();
    phy_conn = 10'h080;
    step();
  endtask

  task automatic t_fs_handoff();
    phy_conn = 10'h090;
    dev_hs_cap[4] = 1'b0;
    #1;
    chk("R4 before edge hs owns", port_owned_cmp, 0);
    step();
    chk("R4 fs to companion", port_owned_cmp, 10'h010);
    chk("R8 cmp sees port 4", cmp_conn_view, 10'h010);
    chk("R9 cmp csc port 4", cmp_csc, 10'h010);
    chk("R1 cmp_chg comp 2", cmp_chg, 5'b00100);
    chk("R9 hs csc port 4 lost", hs_csc, 10'h010);
    chk("R7 tx after handoff", port_tx, exp_tx(10'h010));
    step();
    chk("R9 pulses end", {hs_csc, cmp_csc}, 0);
  endtask

  task automatic t_owner_write();
    own_wr_en = 10'h090;
    own_wr_val = 10'h080;
    step();
    own_wr_en = '0;
    chk("R5 write gives port 7 to companion", port_owned_cmp, 10'h090);
    chk("R1 cmp_chg comp 3", cmp_chg, 5'b01000);
    step();
    own_wr_en = 10'h090;
    own_wr_val = 10'h000;
    step();
    own_wr_en = '0;
    chk("R5 R4 write back, fs stays", port_owned_cmp, 10'h010);
    chk("R7 tx_en after write", port_tx_en, exp_en(10'h010));
    step();
  endtask

  task automatic t_detach();
    phy_conn[4] = 1'b0;
    step();
    chk("R6 detach returns port 4", port_owned_cmp, 0);
    dev_hs_cap[4] = 1'b1;
    phy_conn[4] = 1'b1;
    #1;
    chk("R8 hs sees reattach", hs_conn_view, 10'h090);
    step();
  endtask

  task automatic t_cfg_clear();
    cfg_flag = 1'b0;
    step();
    chk("R2 clear gives all to companions", port_owned_cmp, 10'h3FF);
    chk("R2 hs view empty", hs_conn_view, 0);
    phy_conn = 10'h094;
    dev_hs_cap[2] = 1'b0;
    step();
    cfg_flag = 1'b1;
    step();
    chk("R3 R4 rise with fs port 2", port_owned_cmp, 10'h004);
    chk("R8 hs view after rise", hs_conn_view, 10'h090);
    chk("R7 tx after rise", port_tx, exp_tx(10'h004));
  endtask

  initial begin
    cfg_flag = 0; phy_conn = '0; dev_hs_cap = '1; phy_rx = '0;
    own_wr_en = '0; own_wr_val = '0;
    hs_tx = 20'hAAAAA; cmp_tx = 20'h5A5A5; hs_tx_en = 10'h3FF; cmp_tx_en = 10'h155;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_mapping();
    t_cfg_rise();
    t_fs_handoff();
    t_owner_write();
    t_detach();
    t_cfg_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule